// File: doc/BRIEF.md
# UART Modem-Control Loopback Unit

This unit is the self-test switch of a UART. While its loopback enable is clear, the modem-status flags track the external modem inputs. External received characters and external break events go into the receive path. Transmitted characters leave the chip and are not seen here. While loopback is enabled, the external receive side is cut off. Each character written for transmission is handed straight back to the receive path. A new break request from the line-control break bit is injected as a break entry. The four modem-status flags are driven from the software modem-control outputs held in the control register, with a fixed cross-mapping.

The unit works at character level; no serial timing exists here. Control-register writes and line-control break writes arrive as strobes with data. Receive pushes are issued on two lanes, a character lane and a break lane, one cycle after the event. A single cycle can therefore carry one character and one break, with the character ordered first. A control write that carries the loopback enable also overwrites the modem raw interrupt levels with the looped flag values.

Top module: `uart_loopback_unit`

## Requirements
- R1: After reset the loopback enable is clear (control reset value 0x0300), `mdm_flags` and `mdm_irq` are 0 and neither push lane is valid.
- R2: With loopback clear and no control write carrying the enable, `mdm_flags` equals the `mdm_in` value of the previous cycle. Both use the bit order [3]=ring, [2]=carrier, [1]=data-set-ready, [0]=clear-to-send.
- R3: A control write with bit 7 (loopback enable) set loads `mdm_flags` on the next cycle as follows: ring from bit 13, carrier from bit 12, clear-to-send from bit 11, data-set-ready from bit 10. This includes the write that first turns loopback on.
- R4: The same write sets `mdm_irq` equal to the looped flags, clearing bits as well as setting them.
- R5: While loopback is enabled, `mdm_flags` ignores `mdm_in`.
- R6: With loopback clear, an external character gives a character-lane push on the next cycle with entry {3'b000, data}. An external break gives a break-lane push with entry 0x400 (bit 10 set).
- R7: While loopback is enabled, external characters and external breaks produce no push.
- R8: While loopback is enabled, a transmit write gives a character-lane push of {3'b000, tx_data} on the next cycle.
- R9: With loopback clear, a transmit write produces no push.
- R10: A break-bit write that takes the stored break bit from 0 to 1 while loopback is enabled gives a break-lane push of 0x400. A write that keeps the bit at 1 or clears it gives none. A rise taken while loopback is clear gives none but still updates the stored bit.
- R11: Any event in the same cycle as a control write is judged against the loopback state in force before that write.
- R12: `mdm_irq` changes only on a control write that carries the loopback enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 16 | Control register write value |
| lcr_wr | input | 1 | Line-control write strobe |
| lcr_brk | input | 1 | Break bit of the line-control write |
| tx_wr | input | 1 | Transmit character write strobe |
| tx_data | input | 8 | Transmit character |
| ext_rx_vld | input | 1 | External received character valid |
| ext_rx_data | input | 8 | External received character |
| ext_brk | input | 1 | External break event |
| mdm_in | input | 4 | External modem status inputs |
| mdm_flags | output | 4 | Modem-status flags |
| mdm_irq | output | 4 | Modem raw interrupt levels |
| push_chr_vld | output | 1 | Character-lane receive push |
| push_chr_data | output | 11 | Character-lane entry |
| push_brk_vld | output | 1 | Break-lane receive push |
| push_brk_data | output | 11 | Break-lane entry |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a transmit write and a break-bit rise while loopback is on. The bench drives both strobes in one cycle and expects the character lane and the break lane to be valid together in the next cycle. The second pair is a control write that flips the loopback enable and a data event in the same cycle. The bench flips the enable both ways with a transmit write or an external character alongside. It judges the push against the old enable state, and it checks that the flags hold for one cycle before they resume tracking `mdm_in`.

// File: rtl/uart_lb_pkg.sv
package uart_lb_pkg;
  localparam int DATA_W   = 8;
  localparam int CTRL_W   = 16;
  localparam int MDM_N    = 4;
  localparam int ENTRY_W  = DATA_W + 3;
  localparam int BRK_POS  = DATA_W + 2;

  localparam int LBE_POS  = 7;
  localparam int DTR_POS  = 10;
  localparam int RTS_POS  = 11;
  localparam int OUT1_POS = 12;
  localparam int OUT2_POS = 13;
  localparam logic [CTRL_W-1:0] CTRL_RST = 16'h0300;

  localparam int MI_CTS = 0;
  localparam int MI_DSR = 1;
  localparam int MI_DCD = 2;
  localparam int MI_RI  = 3;

  function automatic logic [MDM_N-1:0] loop_map(input logic [CTRL_W-1:0] c);
    logic [MDM_N-1:0] m;
    m         = '0;
    m[MI_RI]  = c[OUT2_POS];
    m[MI_DCD] = c[OUT1_POS];
    m[MI_CTS] = c[RTS_POS];
    m[MI_DSR] = c[DTR_POS];
    return m;
  endfunction
endpackage

// File: rtl/lb_ctrl_reg.sv
module lb_ctrl_reg
  import uart_lb_pkg::*;
#(
  parameter int CW = CTRL_W,
  parameter int MN = MDM_N
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wr,
  input  logic [CW-1:0] ctrl_wdata,
  input  logic          lcr_wr,
  input  logic          lcr_brk,
  output logic          lb_en,
  output logic          brk_rise,
  output logic          map_wr,
  output logic [MN-1:0] map_val
);
  localparam logic LBE_RST = CTRL_RST[LBE_POS];

  logic lbe_q, lbe_d, lbe_ce;
  logic brk_q, brk_d, brk_ce;

  always_comb begin
    lbe_ce   = ctrl_wr;
    lbe_d    = ctrl_wdata[LBE_POS];
    brk_ce   = lcr_wr;
    brk_d    = lcr_brk;
    brk_rise = lcr_wr & lcr_brk & ~brk_q;
    map_wr   = ctrl_wr & ctrl_wdata[LBE_POS];
    map_val  = loop_map(ctrl_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lbe_q <= LBE_RST;
      brk_q <= 1'b0;
    end else begin
      if (lbe_ce) lbe_q <= lbe_d;
      if (brk_ce) brk_q <= brk_d;
    end
  end

  assign lb_en = lbe_q;

  assert_enable_tracks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (lb_en == $past(ctrl_wdata[LBE_POS])));

  assert_enable_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(lb_en));
endmodule

// File: rtl/lb_modem_map.sv
module lb_modem_map
  import uart_lb_pkg::*;
#(
  parameter int MN = MDM_N
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lb_en,
  input  logic          map_wr,
  input  logic [MN-1:0] map_val,
  input  logic [MN-1:0] mdm_in,
  output logic [MN-1:0] mdm_flags,
  output logic [MN-1:0] mdm_irq
);
  logic [MN-1:0] flg_q, flg_d, irq_q, irq_d;
  logic          flg_ce, irq_ce;

  always_comb begin
    flg_ce = 1'b0;
    flg_d  = flg_q;
    if (map_wr) begin
      flg_ce = 1'b1;
      flg_d  = map_val;
    end else if (!lb_en) begin
      flg_ce = 1'b1;
      flg_d  = mdm_in;
    end
    irq_ce = map_wr;
    irq_d  = map_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '0;
      irq_q <= '0;
    end else begin
      if (flg_ce) flg_q <= flg_d;
      if (irq_ce) irq_q <= irq_d;
    end
  end

  assign mdm_flags = flg_q;
  assign mdm_irq   = irq_q;

  assert_map_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    map_wr |=> (mdm_flags == $past(map_val)));

  assert_irq_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    map_wr |=> (mdm_irq == mdm_flags));

  assert_flags_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_en && !map_wr) |=> $stable(mdm_flags));

  assert_irq_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !map_wr |=> $stable(mdm_irq));
endmodule

// File: rtl/lb_rx_route.sv
module lb_rx_route
  import uart_lb_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int EW = ENTRY_W,
  parameter int BP = BRK_POS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lb_en,
  input  logic          tx_wr,
  input  logic [DW-1:0] tx_data,
  input  logic          ext_rx_vld,
  input  logic [DW-1:0] ext_rx_data,
  input  logic          ext_brk,
  input  logic          brk_rise,
  output logic          push_chr_vld,
  output logic [EW-1:0] push_chr_data,
  output logic          push_brk_vld,
  output logic [EW-1:0] push_brk_data
);
  localparam logic [EW-1:0] BRK_ENTRY = EW'(1) << BP;

  logic          chr_vld_q, chr_vld_d;
  logic [EW-1:0] chr_dat_q, chr_dat_d;
  logic          chr_dat_ce;
  logic          brk_vld_q, brk_vld_d;

  always_comb begin
    if (lb_en) begin
      chr_vld_d = tx_wr;
      chr_dat_d = {{(EW-DW){1'b0}}, tx_data};
      brk_vld_d = brk_rise;
    end else begin
      chr_vld_d = ext_rx_vld;
      chr_dat_d = {{(EW-DW){1'b0}}, ext_rx_data};
      brk_vld_d = ext_brk;
    end
    chr_dat_ce = chr_vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chr_vld_q <= 1'b0;
      chr_dat_q <= '0;
      brk_vld_q <= 1'b0;
    end else begin
      chr_vld_q <= chr_vld_d;
      brk_vld_q <= brk_vld_d;
      if (chr_dat_ce) chr_dat_q <= chr_dat_d;
    end
  end

  assign push_chr_vld  = chr_vld_q;
  assign push_chr_data = chr_dat_q;
  assign push_brk_vld  = brk_vld_q;
  assign push_brk_data = BRK_ENTRY;

  assert_tx_loop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_en && tx_wr) |=> (push_chr_vld && push_chr_data[DW-1:0] == $past(tx_data)));

  assert_ext_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_en && !tx_wr) |=> !push_chr_vld);

  assert_tx_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!lb_en && !ext_rx_vld) |=> !push_chr_vld);

  assert_brk_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    push_brk_vld |-> $past(lb_en ? brk_rise : ext_brk));
endmodule

// File: rtl/uart_loopback_unit.sv
module uart_loopback_unit
  import uart_lb_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CTRL_W,
  parameter int MN = MDM_N,
  parameter int EW = ENTRY_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wr,
  input  logic [CW-1:0] ctrl_wdata,
  input  logic          lcr_wr,
  input  logic          lcr_brk,
  input  logic          tx_wr,
  input  logic [DW-1:0] tx_data,
  input  logic          ext_rx_vld,
  input  logic [DW-1:0] ext_rx_data,
  input  logic          ext_brk,
  input  logic [MN-1:0] mdm_in,
  output logic [MN-1:0] mdm_flags,
  output logic [MN-1:0] mdm_irq,
  output logic          push_chr_vld,
  output logic [EW-1:0] push_chr_data,
  output logic          push_brk_vld,
  output logic [EW-1:0] push_brk_data
);
  logic          lb_en, brk_rise, map_wr;
  logic [MN-1:0] map_val;

  lb_ctrl_reg #(.CW(CW), .MN(MN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .lcr_wr(lcr_wr), .lcr_brk(lcr_brk), .lb_en(lb_en), .brk_rise(brk_rise),
    .map_wr(map_wr), .map_val(map_val)
  );

  lb_modem_map #(.MN(MN)) u_map (
    .clk(clk), .rst_n(rst_n), .lb_en(lb_en), .map_wr(map_wr),
    .map_val(map_val), .mdm_in(mdm_in), .mdm_flags(mdm_flags),
    .mdm_irq(mdm_irq)
  );

  lb_rx_route #(.DW(DW), .EW(EW), .BP(DW + 2)) u_route (
    .clk(clk), .rst_n(rst_n), .lb_en(lb_en), .tx_wr(tx_wr), .tx_data(tx_data),
    .ext_rx_vld(ext_rx_vld), .ext_rx_data(ext_rx_data), .ext_brk(ext_brk),
    .brk_rise(brk_rise), .push_chr_vld(push_chr_vld),
    .push_chr_data(push_chr_data), .push_brk_vld(push_brk_vld),
    .push_brk_data(push_brk_data)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!push_chr_vld && !push_brk_vld && mdm_irq == '0));
endmodule

// File: tb/uart_loopback_unit_bench.sv
`timescale 1ns/1ps
module uart_loopback_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctrl_wr, lcr_wr, lcr_brk, tx_wr, ext_rx_vld, ext_brk;
  logic [15:0] ctrl_wdata;
  logic [7:0]  tx_data, ext_rx_data;
  logic [3:0]  mdm_in, mdm_flags, mdm_irq;
  logic        push_chr_vld, push_brk_vld;
  logic [10:0] push_chr_data, push_brk_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  uart_loopback_unit u_uart_loopback_unit (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .lcr_wr(lcr_wr), .lcr_brk(lcr_brk), .tx_wr(tx_wr), .tx_data(tx_data),
    .ext_rx_vld(ext_rx_vld), .ext_rx_data(ext_rx_data), .ext_brk(ext_brk),
    .mdm_in(mdm_in), .mdm_flags(mdm_flags), .mdm_irq(mdm_irq),
    .push_chr_vld(push_chr_vld), .push_chr_data(push_chr_data),
    .push_brk_vld(push_brk_vld), .push_brk_data(push_brk_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    ctrl_wr = 0; lcr_wr = 0; tx_wr = 0; ext_rx_vld = 0; ext_brk = 0;
  endtask

  // Advance one cycle: inputs driven at a falling edge are taken at the
  // next rising edge; registered outputs are read at the falling edge after.
  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    chk("R1 flags", 32'(mdm_flags), 0);
    chk("R1 irq", 32'(mdm_irq), 0);
    chk("R1 chr lane", 32'(push_chr_vld), 0);
    chk("R1 brk lane", 32'(push_brk_vld), 0);
    tx_wr = 1; tx_data = 8'h11; tick();
    chk("R1/R9 loopback off at reset", 32'(push_chr_vld), 0);
  endtask

  task automatic t_ext_modem();
    mdm_in = 4'b1010; tick();
    chk("R2 flags follow inputs", 32'(mdm_flags), 32'hA);
    mdm_in = 4'b0101; tick();
    chk("R2 flags follow inputs again", 32'(mdm_flags), 32'h5);
    chk("R12 irq untouched", 32'(mdm_irq), 0);
  endtask

  task automatic t_ext_rx();
    ext_rx_vld = 1; ext_rx_data = 8'h5A; tick();
    chk("R6 char push", 32'(push_chr_vld), 1);
    chk("R6 char entry", 32'(push_chr_data), 32'h05A);
    chk("R6 no brk", 32'(push_brk_vld), 0);
    ext_rx_vld = 1; ext_rx_data = 8'hFF; ext_brk = 1; tick();
    chk("R6 both lanes chr", 32'(push_chr_data), 32'h0FF);
    chk("R6 both lanes brk", 32'({push_chr_vld, push_brk_vld}), 32'h3);
    chk("R6 brk entry", 32'(push_brk_data), 32'h400);
    tx_wr = 1; tx_data = 8'h77; tick();
    chk("R9 tx not looped", 32'(push_chr_vld), 0);
    lcr_wr = 1; lcr_brk = 1; tick();
    chk("R10 rise while off no push", 32'(push_brk_vld), 0);
  endtask

  task automatic t_enable_map();
    mdm_in = 4'b0000;
    ctrl_wr = 1; ctrl_wdata = 16'h2880; tick();
    chk("R3 enable write maps", 32'(mdm_flags), 32'h9);
    chk("R4 irq set", 32'(mdm_irq), 32'h9);
    ctrl_wr = 1; ctrl_wdata = 16'h1480; tick();
    chk("R3 remap", 32'(mdm_flags), 32'h6);
    chk("R4 irq overwritten", 32'(mdm_irq), 32'h6);
  endtask

  task automatic t_lb_ignore();
    mdm_in = 4'b1111; ext_rx_vld = 1; ext_rx_data = 8'h33; ext_brk = 1; tick();
    chk("R7 ext char dropped", 32'(push_chr_vld), 0);
    chk("R7 ext brk dropped", 32'(push_brk_vld), 0);
    tick();
    chk("R5 flags ignore inputs", 32'(mdm_flags), 32'h6);
    chk("R12 irq stable", 32'(mdm_irq), 32'h6);
  endtask

  task automatic t_tx_lb();
    tx_wr = 1; tx_data = 8'hC3; tick();
    chk("R8 tx looped", 32'(push_chr_vld), 1);
    chk("R8 tx entry", 32'(push_chr_data), 32'h0C3);
  endtask

  task automatic t_break();
    lcr_wr = 1; lcr_brk = 1; tick();
    chk("R10 bit held from off state", 32'(push_brk_vld), 0);
    lcr_wr = 1; lcr_brk = 0; tick();
    chk("R10 fall no push", 32'(push_brk_vld), 0);
    lcr_wr = 1; lcr_brk = 1; tx_wr = 1; tx_data = 8'h9E; tick();
    chk("R10 rise push", 32'(push_brk_vld), 1);
    chk("R10 brk entry", 32'(push_brk_data), 32'h400);
    chk("R8 tx same cycle", 32'(push_chr_data), 32'h09E);
    chk("R8 chr lane", 32'(push_chr_vld), 1);
    lcr_wr = 1; lcr_brk = 1; tick();
    chk("R10 held high no push", 32'(push_brk_vld), 0);
  endtask

  task automatic t_same_cycle();
    mdm_in = 4'b0011;
    ctrl_wr = 1; ctrl_wdata = 16'h3C00; tx_wr = 1; tx_data = 8'h42; tick();
    chk("R11 tx judged by old state", 32'(push_chr_data), 32'h042);
    chk("R11 push valid", 32'(push_chr_vld), 1);
    chk("R11 flags hold on disable", 32'(mdm_flags), 32'h6);
    chk("R12 irq kept", 32'(mdm_irq), 32'h6);
    tick();
    chk("R2 tracking resumes", 32'(mdm_flags), 32'h3);
    ctrl_wr = 1; ctrl_wdata = 16'h0080; ext_rx_vld = 1; ext_rx_data = 8'hA5; tick();
    chk("R11 ext char by old state", 32'(push_chr_data), 32'h0A5);
    chk("R3 enable-only write", 32'(mdm_flags), 32'h0);
    chk("R4 irq cleared", 32'(mdm_irq), 32'h0);
  endtask

  initial begin
    rst_n = 0; idle(); lcr_brk = 0; ctrl_wdata = '0; tx_data = '0;
    ext_rx_data = '0; mdm_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ext_modem();
    t_ext_rx();
    t_enable_map();
    t_lb_ignore();
    t_tx_lb();
    t_break();
    t_same_cycle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule